// File: doc/BRIEF.md
# TDM Highway Slot and Bit-Mask Selector

This block connects one serial channel to a frame-synchronised time-division highway in both directions. A frame-sync input marks the start of each frame. For each direction, a slot number and a bit offset locate the first bit of the chosen 8-bit slot. An 8-bit mask then picks which bit positions inside that slot carry channel data. Masking out positions of a 64 kbit/s slot gives fractional rates from 8 to 56 kbit/s in steps of 8 kbit/s.

The highway bit clocks and the frame sync are asynchronous to the system clock. They pass through a synchroniser, and the block acts on one selected edge of each highway clock. On the transmit side the serialiser sees a valid/ready stream of single bits. `tx_ready` pulses for one system cycle at each enabled bit. A bit is consumed only when `tx_valid` is high in that cycle. If `tx_valid` is low, an idle one is sent and nothing is consumed. The highway cannot stall, so there is no way to hold a bit back. On the receive side, `rx_valid` pulses once per enabled bit and carries the sampled bit. The receive stream has no ready input because the highway cannot wait. When highway mode is off, every active clock edge carries data.

Top module: `tdm_slot_select`

## Requirements
- R1: The frame-sync input is active high when `fs_pol`=1 and active low when `fs_pol`=0. The active highway edge at which frame sync is sampled active is bit position 0 of the frame, and each later active edge adds one to the position.
- R2: In highway mode, the slot for a direction covers bit positions slot*8+offset up to slot*8+offset+7. The slot number ranges from 0 to 63.
- R3: The bit offset (0 to 7) shifts the slot start later by that many bit positions, separately for each direction.
- R4: Mask bit k enables the k-th bit of the slot, where k=0 is the first bit on the wire. A masked position produces no `tx_ready` or `rx_valid` pulse, and `hwy_dx_oe` stays low for it.
- R5: When the clock-invert input of a direction is 0, that direction acts on the rising edge of its highway clock. When it is 1, it acts on the falling edge.
- R6: For each enabled transmit bit, `tx_ready` pulses for exactly one cycle. `hwy_dx` then takes `tx_bit` if `tx_valid` was high during the pulse, and 1 otherwise. `hwy_dx_oe` goes high. Both are in place within four system cycles of the active edge and hold until the next active edge.
- R7: `tx_slot_active` is high for all eight positions of the transmit slot, masked positions included, and low elsewhere. Outside enabled bits, `hwy_dx` is 1 and `hwy_dx_oe` is 0.
- R8: For each enabled receive bit, `rx_valid` pulses for exactly one cycle within four system cycles of the active edge. `rx_bit` is then the value of `hwy_dr` at that edge.
- R9: With `hwy_en`=0, every active edge is an enabled bit in both directions, and `tx_slot_active` stays high.
- R10: After reset, `hwy_dx`=1 and `hwy_dx_oe`, `tx_slot_active`, `tx_ready` and `rx_valid` are all 0. No bit is selected until the first frame sync. The position count saturates, so a missing frame sync never re-selects a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwy_en | input | 1 | 1 = slot/mask selection, 0 = every edge is data |
| fs_pol | input | 1 | Frame-sync active level |
| fsync | input | 1 | Frame-sync from the highway |
| tx_hwy_clk | input | 1 | Transmit highway bit clock |
| tx_clk_inv | input | 1 | Transmit edge select (0 rising, 1 falling) |
| tx_slot | input | 6 | Transmit slot number |
| tx_bit_off | input | 3 | Transmit bit offset |
| tx_mask | input | 8 | Transmit per-position enable |
| tx_bit | input | 1 | Transmit stream data |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit stream ready (one pulse per enabled bit) |
| hwy_dx | output | 1 | Highway transmit data |
| hwy_dx_oe | output | 1 | Highway transmit drive enable |
| tx_slot_active | output | 1 | Transmit slot in progress |
| rx_hwy_clk | input | 1 | Receive highway bit clock |
| rx_clk_inv | input | 1 | Receive edge select (0 rising, 1 falling) |
| rx_slot | input | 6 | Receive slot number |
| rx_bit_off | input | 3 | Receive bit offset |
| rx_mask | input | 8 | Receive per-position enable |
| hwy_dr | input | 1 | Highway receive data |
| rx_bit | output | 1 | Received data bit |
| rx_valid | output | 1 | Received bit strobe |

## Verification
The assertions assume that each highway clock level lasts at least two system cycles. This keeps synchronised edges apart, so strobes never run into each other. They also assume that frame sync and receive data are stable around the active edge. The stimulus holds every highway clock level for four system cycles. It changes frame sync, receive data and the transmit stream only at the start of the inactive half-period. Configuration changes only between frames, while the clock rests at a level that creates no active edge under the new edge selection.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
  localparam int unsigned DEF_SLOT_W    = 6;
  localparam int unsigned DEF_BOFF_W    = 3;
  localparam int unsigned DEF_SLOT_BITS = 8;
  localparam int unsigned DEF_SYNC      = 2;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
  import tdm_sel_pkg::*;
#(
  parameter int unsigned STAGES = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hwy_clk_i,
  input  logic fs_i,
  input  logic dat_i,
  input  logic inv_i,
  output logic edge_o,
  output logic fs_o,
  output logic dat_o
);
  logic [STAGES:0]   clk_sh;
  logic [STAGES-1:0] fs_sh;
  logic [STAGES-1:0] dat_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh <= '0;
      fs_sh  <= '0;
      dat_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[STAGES-1:0], hwy_clk_i};
      fs_sh  <= {fs_sh[STAGES-2:0], fs_i};
      dat_sh <= {dat_sh[STAGES-2:0], dat_i};
    end
  end

  logic cur_lvl, old_lvl;
  assign cur_lvl = clk_sh[STAGES-1];
  assign old_lvl = clk_sh[STAGES];

  always_comb begin
    if (edge_sel_e'(inv_i) == EDGE_FALL) edge_o = old_lvl & ~cur_lvl;
    else                                 edge_o = ~old_lvl & cur_lvl;
  end
  assign fs_o  = fs_sh[STAGES-1];
  assign dat_o = dat_sh[STAGES-1];

  // R5: a detected edge is a single-cycle event
  a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine
  import tdm_sel_pkg::*;
#(
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned BOFF_W    = DEF_BOFF_W,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 edge_i,
  input  logic                 fs_act_i,
  input  logic                 hwy_en_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [BOFF_W-1:0]    boff_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  output logic                 tick_o,
  output logic                 sel_o,
  output logic                 active_o
);
  localparam int unsigned IDX_W = $clog2(SLOT_BITS);
  localparam int unsigned POS_W = SLOT_W + IDX_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, pos_nxt, start, rel;
  logic             in_slot;
  logic [IDX_W-1:0] idx;

  assign start = POS_W'({slot_i, {IDX_W{1'b0}}}) + POS_W'(boff_i);

  always_comb begin
    if (fs_act_i)              pos_nxt = '0;
    else if (pos_q == POS_MAX) pos_nxt = pos_q;
    else                       pos_nxt = pos_q + 1'b1;
    rel     = pos_nxt - start;
    in_slot = (pos_nxt >= start) && (rel < POS_W'(SLOT_BITS));
    idx     = rel[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= POS_MAX;
      tick_o   <= 1'b0;
      sel_o    <= 1'b0;
      active_o <= 1'b0;
    end else begin
      tick_o <= edge_i;
      if (edge_i) begin
        pos_q    <= pos_nxt;
        active_o <= !hwy_en_i || in_slot;
        sel_o    <= !hwy_en_i || (in_slot && mask_i[idx]);
      end
    end
  end

  // R6: bit ticks are single-cycle pulses
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R1: a frame-sync edge restarts the position count
  a_r1_fs_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && fs_act_i) |=> (pos_q == '0));
endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
  import tdm_sel_pkg::*;
#(
  parameter int unsigned SLOT_W      = DEF_SLOT_W,
  parameter int unsigned BOFF_W      = DEF_BOFF_W,
  parameter int unsigned SLOT_BITS   = DEF_SLOT_BITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hwy_en,
  input  logic                 fs_pol,
  input  logic                 fsync,
  input  logic                 tx_hwy_clk,
  input  logic                 tx_clk_inv,
  input  logic [SLOT_W-1:0]    tx_slot,
  input  logic [BOFF_W-1:0]    tx_bit_off,
  input  logic [SLOT_BITS-1:0] tx_mask,
  input  logic                 tx_bit,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 hwy_dx,
  output logic                 hwy_dx_oe,
  output logic                 tx_slot_active,
  input  logic                 rx_hwy_clk,
  input  logic                 rx_clk_inv,
  input  logic [SLOT_W-1:0]    rx_slot,
  input  logic [BOFF_W-1:0]    rx_bit_off,
  input  logic [SLOT_BITS-1:0] rx_mask,
  input  logic                 hwy_dr,
  output logic                 rx_bit,
  output logic                 rx_valid
);
  logic tx_edge, tx_fs, tx_dat_unused, rx_edge, rx_fs, rx_dat;
  logic tx_tick, tx_sel, rx_tick, rx_sel, rx_active_unused, rx_dat_q;

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .hwy_clk_i(tx_hwy_clk), .fs_i(fsync),
    .dat_i(1'b0), .inv_i(tx_clk_inv), .edge_o(tx_edge), .fs_o(tx_fs),
    .dat_o(tx_dat_unused));

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .hwy_clk_i(rx_hwy_clk), .fs_i(fsync),
    .dat_i(hwy_dr), .inv_i(rx_clk_inv), .edge_o(rx_edge), .fs_o(rx_fs),
    .dat_o(rx_dat));

  tdm_slot_engine #(.SLOT_W(SLOT_W), .BOFF_W(BOFF_W), .SLOT_BITS(SLOT_BITS)) u_tx_eng (
    .clk(clk), .rst_n(rst_n), .edge_i(tx_edge), .fs_act_i(tx_fs == fs_pol),
    .hwy_en_i(hwy_en), .slot_i(tx_slot), .boff_i(tx_bit_off), .mask_i(tx_mask),
    .tick_o(tx_tick), .sel_o(tx_sel), .active_o(tx_slot_active));

  tdm_slot_engine #(.SLOT_W(SLOT_W), .BOFF_W(BOFF_W), .SLOT_BITS(SLOT_BITS)) u_rx_eng (
    .clk(clk), .rst_n(rst_n), .edge_i(rx_edge), .fs_act_i(rx_fs == fs_pol),
    .hwy_en_i(hwy_en), .slot_i(rx_slot), .boff_i(rx_bit_off), .mask_i(rx_mask),
    .tick_o(rx_tick), .sel_o(rx_sel), .active_o(rx_active_unused));

  assign tx_ready = tx_tick & tx_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwy_dx    <= 1'b1;
      hwy_dx_oe <= 1'b0;
      rx_dat_q  <= 1'b0;
      rx_bit    <= 1'b0;
      rx_valid  <= 1'b0;
    end else begin
      if (tx_tick) begin
        hwy_dx    <= tx_sel ? (tx_valid ? tx_bit : 1'b1) : 1'b1;
        hwy_dx_oe <= tx_sel;
      end
      if (rx_edge) rx_dat_q <= rx_dat;
      rx_valid <= rx_tick & rx_sel;
      if (rx_tick && rx_sel) rx_bit <= rx_dat_q;
    end
  end

  // R6: transmit ready only ever inside the transmit slot
  a_r6_ready_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_slot_active);
  // R7: the line idles high whenever it is not driven
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !hwy_dx_oe |-> hwy_dx);
  // R8: one receive strobe per enabled bit
  a_r8_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/test_tdm_slot_select.sv
module test_tdm_slot_select;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hwy_en, fs_pol, fsync, hclk, inv;
  logic [5:0] tx_slot, rx_slot;
  logic [2:0] tx_bit_off, rx_bit_off;
  logic [7:0] tx_mask, rx_mask;
  logic tx_bit, tx_valid, tx_ready, hwy_dx, hwy_dx_oe, tx_slot_active;
  logic hwy_dr, rx_bit, rx_valid;

  tdm_slot_select i_tdm_slot_select (
    .clk(clk), .rst_n(rst_n), .hwy_en(hwy_en), .fs_pol(fs_pol), .fsync(fsync),
    .tx_hwy_clk(hclk), .tx_clk_inv(inv), .tx_slot(tx_slot), .tx_bit_off(tx_bit_off),
    .tx_mask(tx_mask), .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .hwy_dx(hwy_dx), .hwy_dx_oe(hwy_dx_oe), .tx_slot_active(tx_slot_active),
    .rx_hwy_clk(hclk), .rx_clk_inv(inv), .rx_slot(rx_slot), .rx_bit_off(rx_bit_off),
    .rx_mask(rx_mask), .hwy_dr(hwy_dr), .rx_bit(rx_bit), .rx_valid(rx_valid));

  int vectors = 0, errors = 0;
  int pos_tx = 1023, pos_rx = 1023;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int adv(int p, bit fs);
    if (fs) return 0;
    return (p >= 1023) ? 1023 : p + 1;
  endfunction

  function automatic bit in_win(int p, int slot, int off);
    int st = slot * 8 + off;
    return (p >= st) && (p - st < 8);
  endfunction

  task automatic do_bit(bit fs_act, bit dr, bit tv, bit tb);
    int n_rdy = 0, n_rv = 0;
    bit rb = 0, tin, rin, tsel, tact, rsel;
    hclk = inv; fsync = fs_pol ? fs_act : ~fs_act;
    hwy_dr = dr; tx_valid = tv; tx_bit = tb;
    repeat (4) @(negedge clk);
    hclk = ~inv;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (tx_ready) n_rdy++;
      if (rx_valid) begin n_rv++; rb = rx_bit; end
    end
    pos_tx = adv(pos_tx, fs_act);
    pos_rx = adv(pos_rx, fs_act);
    tin  = in_win(pos_tx, tx_slot, tx_bit_off);
    rin  = in_win(pos_rx, rx_slot, rx_bit_off);
    tact = !hwy_en || tin;
    tsel = !hwy_en || (tin && tx_mask[pos_tx - (tx_slot*8 + tx_bit_off)]);
    rsel = !hwy_en || (rin && rx_mask[pos_rx - (rx_slot*8 + rx_bit_off)]);
    chk("R4/R6", "tx_ready pulses", n_rdy, tsel);
    chk("R7/R9", "tx_slot_active", tx_slot_active, tact);
    chk("R6/R4", "hwy_dx_oe", hwy_dx_oe, tsel);
    chk("R6/R7", "hwy_dx", hwy_dx, tsel ? (tv ? tb : 1) : 1);
    chk("R8/R4", "rx_valid pulses", n_rv, rsel);
    if (rsel) chk("R8", "rx_bit", rb, dr);
  endtask

  task automatic run_frame(int nbits);
    for (int b = 0; b < nbits; b++)
      do_bit(b == 0, 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  function automatic int flen();
    int a = tx_slot * 8 + tx_bit_off, r = rx_slot * 8 + rx_bit_off;
    return ((a > r) ? a : r) + 10;
  endfunction

  initial begin
    void'($urandom(32'h7D5));
    rst_n = 0; hwy_en = 1; fs_pol = 1; fsync = 0; inv = 0; hclk = 0;
    tx_slot = 0; tx_bit_off = 0; tx_mask = 8'hFF; rx_slot = 1; rx_bit_off = 3; rx_mask = 8'h55;
    tx_bit = 0; tx_valid = 0; hwy_dr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "reset hwy_dx", hwy_dx, 1);
    chk("R10", "reset hwy_dx_oe", hwy_dx_oe, 0);
    chk("R10", "reset tx_slot_active", tx_slot_active, 0);
    chk("R10", "reset tx_ready", tx_ready, 0);
    chk("R10", "reset rx_valid", rx_valid, 0);
    // R10: edges before any frame sync select nothing
    for (int i = 0; i < 12; i++) do_bit(0, 1, 1, 0);
    // R1 R2 R3 R5: rising edges, active-high sync, offsets
    run_frame(flen());
    // R5 R1: falling edges, active-low sync, odd mask, empty receive mask
    inv = 1; fs_pol = 0; tx_slot = 2; tx_bit_off = 5; tx_mask = 8'h81;
    rx_slot = 0; rx_bit_off = 0; rx_mask = 8'h00;
    run_frame(flen());
    // R2 R3: highest slot and offset
    tx_slot = 63; tx_bit_off = 7; tx_mask = 8'hA5; rx_slot = 63; rx_bit_off = 0; rx_mask = 8'hFF;
    run_frame(flen());
    // R9: highway mode off
    hwy_en = 0;
    run_frame(12);
    hwy_en = 1;
    // random frames
    for (int f = 0; f < 12; f++) begin
      inv = 1'($urandom); fs_pol = 1'($urandom);
      tx_slot = 6'($urandom_range(0, 7)); tx_bit_off = 3'($urandom); tx_mask = 8'($urandom);
      rx_slot = 6'($urandom_range(0, 7)); rx_bit_off = 3'($urandom); rx_mask = 8'($urandom);
      run_frame(flen());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule